// File: doc/BRIEF.md
# Receive Self-Test Character Checker

This block sits behind the character decoder of one receive channel. When a receive self-test mode is selected, it stops passing received characters through. It first waits for the receive PLL to report lock. It then hunts the incoming stream for a start-of-pattern character. Once that character is found, it runs a 9-bit maximal-length LFSR and compares every valid character that follows against the low eight bits of the LFSR state.

For every cycle, the outcome is turned into a 3-bit status code. The code is placed on the parallel output in place of received data: the most significant code bit goes on a flag line, and the two lower code bits go on the two lowest data lines in swapped order. The code distinguishes these cases: waiting for lock, hunting for the start character, a matching character, a mismatching character, and whether the final character of each 511-character pattern repetition matched. After the final character, checking carries on with the next repetition without hunting again. Losing lock or leaving self-test mode discards all pattern progress.

When the mode control selects normal reception, characters pass straight through with one cycle of latency.

Top module: `rbist_checker`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid`, `out_flag` and `out_data` are all zero.
- R2: When `rx_mode` is not 2'b10 (2'b01 is normal reception), then one cycle later `out_valid` equals `in_valid`, `out_data` equals `in_data` and `out_flag` is 0.
- R3: When `rx_mode` is 2'b10 (self-test), a status code C[2:0] is shown as follows: `out_flag`=C[2], `out_data[0]`=C[1], `out_data[1]`=C[0], and `out_data[7:2]`=0. The codes are: 000 good, 010 last good, 011 start, 101 last bad, 110 error, 111 wait.
- R4: In self-test mode with `pll_locked` low, the code one cycle later is 011 with `out_valid` high, on every cycle.
- R5: The first locked cycle after the start state still reports 011. From then on, each valid character reports 111 until the start character 8'hBC arrives. The start character itself also reports 111.
- R6: The k-th valid character after the start character (k from 0) is compared with the low 8 bits of S_k. Here S_0=9'h1FF and S_(k+1)={S_k[7:0], S_k[8]^S_k[4]}. A match reports 000.
- R7: A character that differs from the expected value in any bit reports 110, and the pattern still advances.
- R8: The character compared against the state whose successor is S_0 (k=510) is the last of a repetition. It reports 010 if it matches and 101 if it does not.
- R9: After the last character, comparison continues at S_0 with no new start character.
- R10: Losing lock or leaving self-test mode returns the checker to the start state and clears the pattern. A new start character is then required.
- R11: Code 100 is never produced.
- R12: While hunting or comparing, a cycle with `in_valid` low gives `out_valid` low and does not advance the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode | input | 2 | Reception mode: 01 normal, 10 self-test |
| pll_locked | input | 1 | Receive PLL lock indication |
| in_valid | input | 1 | Decoded character strobe |
| in_data | input | 8 | Decoded character |
| out_valid | output | 1 | Output character or status valid |
| out_flag | output | 1 | Status high bit (0 in normal mode) |
| out_data | output | 8 | Passed data, or status low bits in self-test mode |

## Verification
The assertions check on every cycle the properties that do not depend on history. These are: the normal-mode pass-through, the zero upper data bits in self-test mode, the start code while unlocked, and the absence of the reserved code. Only the bench scenarios can show the properties that depend on history. These are: hunting for the start character, the LFSR sequence itself, the position of the last character at 511 characters, and continuation into the next repetition without a new start character. The same holds for the effect of idle cycles and the forced re-hunt after lock loss or a mode change.

// File: rtl/rbist_pkg.sv
package rbist_pkg;

    localparam int CHAR_W  = 8;
    localparam int LFSR_W  = 9;
    localparam logic [1:0] MODE_BIST = 2'b10;
    localparam logic [2:0] CODE_RSVD = 3'b100;

    typedef enum logic [2:0] {
        C_GOOD      = 3'b000,
        C_LAST_GOOD = 3'b010,
        C_START     = 3'b011,
        C_LAST_BAD  = 3'b101,
        C_ERROR     = 3'b110,
        C_WAIT      = 3'b111
    } bist_code_e;

    typedef enum logic [1:0] {
        PH_START,
        PH_HUNT,
        PH_CHECK
    } phase_e;

    typedef struct packed {
        logic       valid;
        bist_code_e code;
    } status_t;

    typedef struct packed {
        logic clr;
        logic load;
        logic adv;
    } lfsr_cmd_t;

    // Fibonacci step: shift left, feedback is parity of tapped bits
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                    input logic [LFSR_W-1:0] taps);
        return {s[LFSR_W-2:0], ^(s & taps)};
    endfunction

    // Place code on flag plus swapped low data lines
    function automatic logic [CHAR_W:0] code_to_bus(input bist_code_e c);
        logic [CHAR_W:0] b;
        b = '0;
        b[CHAR_W] = c[2];
        b[0]      = c[1];
        b[1]      = c[0];
        return b;
    endfunction

endpackage

// File: rtl/rbist_lfsr.sv
module rbist_lfsr
    import rbist_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 9'h1FF,
    parameter logic [LFSR_W-1:0] TAPS = 9'h110
) (
    input  logic              clk,
    input  logic              rst,
    input  lfsr_cmd_t         cmd,
    output logic [CHAR_W-1:0] expected,
    output logic              last
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_nx;

    assign state_nx = lfsr_step(state_q, TAPS);
    assign expected = state_q[CHAR_W-1:0];
    assign last     = (state_nx == SEED);

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            state_q <= '0;
        end else if (cmd.load) begin
            state_q <= SEED;
        end else if (cmd.adv) begin
            state_q <= state_nx;
        end
    end
endmodule

// File: rtl/rbist_ctrl.sv
module rbist_ctrl
    import rbist_pkg::*;
#(
    parameter logic [CHAR_W-1:0] START_CHAR = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_en,
    input  logic              pll_locked,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic [CHAR_W-1:0] expected,
    input  logic              last,
    output lfsr_cmd_t         cmd,
    output status_t           status
);
    phase_e phase_q, phase_d;
    logic   match;

    assign match = (in_data == expected);

    always_comb begin
        phase_d      = phase_q;
        cmd          = '0;
        status.valid = 1'b0;
        status.code  = C_START;
        if (!bist_en) begin
            phase_d = PH_START;
            cmd.clr = 1'b1;
        end else if (!pll_locked) begin
            phase_d      = PH_START;
            cmd.clr      = 1'b1;
            status.valid = 1'b1;
        end else begin
            unique case (phase_q)
                PH_START: begin
                    status.valid = 1'b1;
                    phase_d      = PH_HUNT;
                end
                PH_HUNT: begin
                    if (in_valid) begin
                        status.valid = 1'b1;
                        status.code  = C_WAIT;
                        if (in_data == START_CHAR) begin
                            cmd.load = 1'b1;
                            phase_d  = PH_CHECK;
                        end
                    end
                end
                PH_CHECK: begin
                    if (in_valid) begin
                        status.valid = 1'b1;
                        cmd.adv      = 1'b1;
                        if (match) status.code = last ? C_LAST_GOOD : C_GOOD;
                        else       status.code = last ? C_LAST_BAD  : C_ERROR;
                    end
                end
                default: phase_d = PH_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_START;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/rbist_fmt.sv
module rbist_fmt
    import rbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_en,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  status_t           status,
    output logic              out_valid,
    output logic              out_flag,
    output logic [CHAR_W-1:0] out_data
);
    logic [CHAR_W:0] bus;

    assign bus = code_to_bus(status.code);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flag  <= 1'b0;
            out_data  <= '0;
        end else if (!bist_en) begin
            out_valid <= in_valid;
            out_flag  <= 1'b0;
            out_data  <= in_data;
        end else if (status.valid) begin
            out_valid <= 1'b1;
            out_flag  <= bus[CHAR_W];
            out_data  <= bus[CHAR_W-1:0];
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rbist_checker.sv
module rbist_checker
    import rbist_pkg::*;
#(
    parameter logic [CHAR_W-1:0] START_CHAR = 8'hBC,
    parameter logic [LFSR_W-1:0] SEED       = 9'h1FF,
    parameter logic [LFSR_W-1:0] TAPS       = 9'h110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rx_mode,
    input  logic              pll_locked,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_flag,
    output logic [CHAR_W-1:0] out_data
);
    logic              bist_en;
    lfsr_cmd_t         cmd;
    status_t           status;
    logic [CHAR_W-1:0] expected;
    logic              last;

    assign bist_en = (rx_mode == MODE_BIST);

    rbist_lfsr #(.SEED(SEED), .TAPS(TAPS)) lfsr_i (
        .clk(clk), .rst(rst), .cmd(cmd), .expected(expected), .last(last)
    );

    rbist_ctrl #(.START_CHAR(START_CHAR)) ctrl_i (
        .clk(clk), .rst(rst), .bist_en(bist_en), .pll_locked(pll_locked),
        .in_valid(in_valid), .in_data(in_data), .expected(expected),
        .last(last), .cmd(cmd), .status(status)
    );

    rbist_fmt fmt_i (
        .clk(clk), .rst(rst), .bist_en(bist_en), .in_valid(in_valid),
        .in_data(in_data), .status(status), .out_valid(out_valid),
        .out_flag(out_flag), .out_data(out_data)
    );
endmodule

// File: rtl/rbist_checker_sva.sv
module rbist_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic [1:0] rx_mode,
    input logic       pll_locked,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_flag,
    input logic [7:0] out_data
);
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_mode != 2'b10) |=> (out_valid == $past(in_valid) &&
                                out_data == $past(in_data) && !out_flag));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == 2'b10) |=> (out_data[7:2] == 6'd0));

    // R4
    unlocked_start_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == 2'b10 && !pll_locked) |=>
            (out_valid && !out_flag && out_data == 8'h03));

    // R11
    no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_flag && out_data[1:0] == 2'b00));
endmodule

bind rbist_checker rbist_checker_sva sva_i (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .pll_locked(pll_locked),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_flag(out_flag), .out_data(out_data)
);

// File: tb/rbist_checker_tb.sv
module rbist_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] rx_mode;
    logic       pll_locked;
    logic       in_valid;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_flag;
    logic [7:0] out_data;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 0;
    bit  saw_rsvd = 0;
    logic [8:0] s;

    always #2 clk = ~clk;

    rbist_checker dut_i (
        .clk(clk), .rst(rst), .rx_mode(rx_mode), .pll_locked(pll_locked),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_flag(out_flag), .out_data(out_data)
    );

    function automatic logic [8:0] nxt(input logic [8:0] v);
        return {v[7:0], v[8] ^ v[4]};
    endfunction

    task automatic cyc(input logic [1:0] m, input logic lk, input logic v,
                       input logic [7:0] d);
        rx_mode = m; pll_locked = lk; in_valid = v; in_data = d;
        @(posedge clk);
        #1;
        if (out_valid && out_flag && out_data[1:0] == 2'b00) saw_rsvd = 1;
    endtask

    task automatic chk_code(input logic [2:0] exp, input string req);
        logic [2:0] got;
        got = {out_flag, out_data[0], out_data[1]};
        n_checks++;
        if (!out_valid || got != exp || out_data[7:2] != 6'd0) begin
            n_err++;
            $display("FAIL %s: valid=%0b code=%b upper=%h expected code=%b",
                     req, out_valid, got, out_data[7:2], exp);
        end
    endtask

    task automatic chk_idle(input string req);
        n_checks++;
        if (out_valid) begin
            n_err++;
            $display("FAIL %s: out_valid=1 expected 0", req);
        end
    endtask

    initial begin
        rst = 1; rx_mode = 2'b01; pll_locked = 0; in_valid = 0; in_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1
        n_checks++;
        if (out_valid || out_flag || out_data != 8'h00) begin
            n_err++;
            $display("FAIL R1: v=%0b f=%0b d=%h expected 0 0 00", out_valid, out_flag, out_data);
        end
        rst = 0;
        cyc(2'b01, 0, 0, 8'h00);
        // R1 after release, idle input
        n_checks++;
        if (out_valid || out_flag || out_data != 8'h00) begin
            n_err++;
            $display("FAIL R1: v=%0b f=%0b d=%h expected 0 0 00", out_valid, out_flag, out_data);
        end

        // R2: full sweep in normal and unused modes
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            for (int d = 0; d < 256; d++) begin
                cyc(m[1:0], d[0], d[1] | d[3], d[7:0]);
                n_checks++;
                if (out_valid != (d[1] | d[3]) || out_data != d[7:0] || out_flag) begin
                    n_err++;
                    $display("FAIL R2: v=%0b d=%h f=%0b expected v=%0b d=%h f=0",
                             out_valid, out_data, out_flag, d[1] | d[3], d[7:0]);
                end
            end
        end

        // R4, R3: unlocked start code
        for (int i = 0; i < 5; i++) begin
            cyc(2'b10, 0, i[0], 8'hBC);
            chk_code(3'b011, "R4");
        end
        // R5: first locked cycle still start
        cyc(2'b10, 1, 0, 8'h00);
        chk_code(3'b011, "R5");
        // R5: hunt sweep excluding the start character
        for (int d = 0; d < 256; d++) begin
            if (d == 8'hBC) continue;
            cyc(2'b10, 1, 1, d[7:0]);
            chk_code(3'b111, "R5");
        end
        // R12 while hunting
        cyc(2'b10, 1, 0, 8'hBC);
        chk_idle("R12");
        cyc(2'b10, 1, 1, 8'hBC);
        chk_code(3'b111, "R5");

        // R6, R8, R12: full correct repetition with idle gaps
        s = 9'h1FF;
        for (int k = 0; k < 511; k++) begin
            if (k % 7 == 3) begin
                cyc(2'b10, 1, 0, s[7:0] ^ 8'h5A);
                chk_idle("R12");
            end
            cyc(2'b10, 1, 1, s[7:0]);
            chk_code((k == 510) ? 3'b010 : 3'b000, (k == 510) ? "R8" : "R6");
            s = nxt(s);
        end
        // R9, R7, R8: next repetition with single-bit errors and bad last
        for (int k = 0; k < 511; k++) begin
            logic bad;
            bad = (k == 0) || (k % 50 == 17) || (k == 510);
            cyc(2'b10, 1, 1, bad ? (s[7:0] ^ (8'h01 << (k % 8))) : s[7:0]);
            if (k == 510)   chk_code(3'b101, "R8");
            else if (bad)   chk_code(3'b110, "R7");
            else            chk_code(3'b000, "R9");
            s = nxt(s);
        end
        // R9: third repetition starts cleanly
        for (int k = 0; k < 20; k++) begin
            cyc(2'b10, 1, 1, s[7:0]);
            chk_code(3'b000, "R9");
            s = nxt(s);
        end

        // R10: lock loss mid-sequence
        cyc(2'b10, 0, 1, s[7:0]);
        chk_code(3'b011, "R10");
        cyc(2'b10, 1, 0, 8'h00);
        chk_code(3'b011, "R10");
        cyc(2'b10, 1, 1, 8'hFF);
        chk_code(3'b111, "R10");
        cyc(2'b10, 1, 1, 8'hBC);
        chk_code(3'b111, "R10");
        s = 9'h1FF;
        for (int k = 0; k < 5; k++) begin
            cyc(2'b10, 1, 1, s[7:0]);
            chk_code(3'b000, "R10");
            s = nxt(s);
        end

        // R10: leaving self-test mode mid-sequence
        cyc(2'b01, 1, 1, 8'hA5);
        n_checks++;
        if (!out_valid || out_data != 8'hA5 || out_flag) begin
            n_err++;
            $display("FAIL R2: v=%0b d=%h expected v=1 d=a5", out_valid, out_data);
        end
        cyc(2'b10, 1, 1, s[7:0]);
        chk_code(3'b011, "R10");
        cyc(2'b10, 1, 1, s[7:0]);
        chk_code(3'b111, "R10");

        // R11
        n_checks++;
        if (saw_rsvd) begin
            n_err++;
            $display("FAIL R11: reserved code seen=1 expected 0");
        end
        done = 1;
    end

    initial begin
        int cnt;
        cnt = 0;
        while (!done && cnt < 150000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: cycles=%0d expected completion", cnt);
        end
        #1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule